// File: doc/BRIEF.md
# Inter-core message queue unit

A mailbox shared by a small group of cores. Every core owns a receive queue of fixed-width messages, and each stored entry carries the sender's core number with it. In any cycle a core may issue one request. It can send a message to any core, itself included. It can take the oldest message from its own queue, empty its own queue, or ask whether a send or a receive would succeed right now. Each request gets a registered response that carries an accept flag, a trap flag and, on a successful receive, the message and its sender.

A receive comes in two kinds. The non-blocking kind traps at once when the queue is empty. The blocking kind parks the core until a message arrives. Supervisor software has a separate port. Through it, software can write a message into any queue, and it can set or clear a per-receiver overflow flag. While that flag is set, a receive that finds the queue empty traps rather than waiting. This lets software move spilled messages back into the hardware queue in their original order. When several cores send to the same target in one cycle, the lowest-numbered sender is served.

Top module: `mq_unit`

## Requirements
- R1: A send (req_op 0) whose target queue is not full at the start of the cycle, and which wins arbitration, answers ok=1 trap=0 and appends {sender number, data} to that queue.
- R2: A winning send to a queue that already holds DEPTH entries answers ok=0 trap=1 and leaves the queue unchanged.
- R3: When several sends name the same target in one cycle, only the lowest-numbered core is considered. Every other sender gets ok=0 trap=0 and nothing is enqueued for it. A supervisor refill to that target beats all sends.
- R4: A non-blocking receive (req_op 1, req_mode 0) on a non-empty queue answers ok=1 with the oldest data and its sender. On an empty queue it answers ok=0 trap=1.
- R5: Messages leave each queue in the order in which they were written.
- R6: A blocking receive (req_op 1, req_mode 1) on an empty queue whose overflow flag is clear gives no response. Other requests from that core are ignored while it waits. The cycle after a message becomes present, the receive completes with ok=1 and that message.
- R7: When the overflow flag is set, any receive that meets an empty queue answers trap=1, and so does a receive that is already waiting.
- R8: A flush (req_op 2) answers ok=1 and discards every entry present at the start of the cycle. A write in that same cycle is kept.
- R9: A select (req_op 3) never changes state and answers trap=0. With req_mode 1 it sets ok to whether the own queue is non-empty. With req_mode 0 it sets ok to whether the target queue is not full.
- R10: Receives and fullness decisions see only queue contents from the start of the cycle. A message written in a cycle is not visible to a receive in that same cycle.
- R11: Supervisor port ops: 0 writes {sup_src, sup_data} into queue sup_core (dropped if full), 1 sets the overflow flag of sup_core, 2 clears it, and 3 is idle.
- R12: Each accepted request gets exactly one response, one cycle after it is issued (or on completion for a waiting receive). No response appears without a cause, and none appears after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_CORES | Request strobe per core |
| req_op | input | 2*N_CORES | Operation per core: 0 send, 1 receive, 2 flush, 3 select |
| req_mode | input | N_CORES | Receive: 1 blocking. Select: 1 query receive, 0 query send |
| req_target | input | IDW*N_CORES | Target core of a send or send query |
| req_data | input | DATA_W*N_CORES | Message payload of a send |
| sup_op | input | 2 | Supervisor op: 0 refill, 1 set overflow, 2 clear overflow, 3 idle |
| sup_core | input | IDW | Core addressed by the supervisor op |
| sup_src | input | IDW | Sender number recorded with a refilled message |
| sup_data | input | DATA_W | Payload of a refilled message |
| rsp_valid | output | N_CORES | Response strobe per core |
| rsp_ok | output | N_CORES | Request accepted or query true |
| rsp_trap | output | N_CORES | Trap indication |
| rsp_data | output | DATA_W*N_CORES | Received payload |
| rsp_src | output | IDW*N_CORES | Sender number of the received payload |

## Verification
The bench uses the defaults: four cores, a depth of four entries and a 32-bit payload. A queue fills after only four sends, so the full-target trap and the same-cycle refill and send collisions come up often in random traffic. With four cores, three senders can contend for one target while a fourth core receives or waits. The overflow flag is toggled at random, so it also meets parked blocking receives.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef enum logic [1:0] {
    OP_SEND   = 2'd0,
    OP_RECV   = 2'd1,
    OP_FLUSH  = 2'd2,
    OP_SELECT = 2'd3
  } mq_op_e;

  typedef enum logic [1:0] {
    SUP_REFILL  = 2'd0,
    SUP_SET_OVF = 2'd1,
    SUP_CLR_OVF = 2'd2,
    SUP_IDLE    = 2'd3
  } mq_sup_e;
endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 34
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  input  logic                       flush,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (flush)    rd_ptr <= wr_ptr;
      else if (pop) rd_ptr <= nxt(rd_ptr);
      cnt <= (flush ? '0 : cnt - CW'(pop)) + CW'(push);
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt;

  // R2: a write is never issued into a full queue
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt != CW'(DEPTH)));
  // R4: a read is never issued from an empty queue
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
  // R8: after a flush only the same-cycle write can remain
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == CW'($past(push))));
endmodule

// File: rtl/mq_arbiter.sv
module mq_arbiter #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   send_req,
  input  logic [N*IDW-1:0] send_tgt,
  input  logic [N-1:0]   tgt_block,
  output logic [N-1:0]   grant
);
  logic [N-1:0] g_to [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grant[i] = send_req[i] && !tgt_block[send_tgt[i*IDW +: IDW]];
      for (int j = 0; j < i; j++) begin
        if (send_req[j] && (send_tgt[j*IDW +: IDW] == send_tgt[i*IDW +: IDW]))
          grant[i] = 1'b0;
      end
    end
    for (int t = 0; t < N; t++)
      for (int i = 0; i < N; i++)
        g_to[t][i] = grant[i] && (send_tgt[i*IDW +: IDW] == IDW'(t));
  end

  for (genvar t = 0; t < N; t++) begin : g_chk
    // R3: at most one sender is served per target
    a_r3_one_winner: assert property (@(posedge clk) disable iff (rst)
      $onehot0(g_to[t]));
  end
endmodule

// File: rtl/mq_unit.sv
module mq_unit
  import mq_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 32,
  parameter int IDW     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_CORES-1:0]       req_valid,
  input  logic [2*N_CORES-1:0]     req_op,
  input  logic [N_CORES-1:0]       req_mode,
  input  logic [IDW*N_CORES-1:0]   req_target,
  input  logic [DATA_W*N_CORES-1:0] req_data,
  input  logic [1:0]               sup_op,
  input  logic [IDW-1:0]           sup_core,
  input  logic [IDW-1:0]           sup_src,
  input  logic [DATA_W-1:0]        sup_data,
  output logic [N_CORES-1:0]       rsp_valid,
  output logic [N_CORES-1:0]       rsp_ok,
  output logic [N_CORES-1:0]       rsp_trap,
  output logic [DATA_W*N_CORES-1:0] rsp_data,
  output logic [IDW*N_CORES-1:0]   rsp_src
);
  localparam int N  = N_CORES;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = IDW + DATA_W;

  logic [CW-1:0]  cnt       [N];
  logic [EW-1:0]  head      [N];
  logic [EW-1:0]  push_data [N];
  logic [IDW-1:0] tgt       [N];
  logic [N-1:0]   push, pop, flush, full, refill_hit, is_send, grant;
  logic [N-1:0]   waiting, wait_n, ovf;
  logic [N-1:0]   nv, nok, ntrap;
  logic [DATA_W-1:0] ndata [N];
  logic [IDW-1:0]    nsrc  [N];
  mq_sup_e        sup_e;

  assign sup_e = mq_sup_e'(sup_op);

  always_comb begin
    for (int c = 0; c < N; c++) begin
      tgt[c]        = req_target[c*IDW +: IDW];
      is_send[c]    = req_valid[c] && !waiting[c] &&
                      (mq_op_e'(req_op[c*2 +: 2]) == OP_SEND);
      full[c]       = (cnt[c] == CW'(DEPTH));
      refill_hit[c] = (sup_e == SUP_REFILL) && (sup_core == IDW'(c));
    end
  end

  mq_arbiter #(.N(N), .IDW(IDW)) u_arb (
    .clk(clk), .rst(rst), .send_req(is_send), .send_tgt(req_target),
    .tgt_block(refill_hit), .grant(grant)
  );

  // write side: refill first, then the arbitration winner
  always_comb begin
    for (int t = 0; t < N; t++) begin
      push[t]      = 1'b0;
      push_data[t] = '0;
      if (refill_hit[t]) begin
        push[t]      = !full[t];
        push_data[t] = {sup_src, sup_data};
      end else begin
        for (int c = 0; c < N; c++) begin
          if (grant[c] && (tgt[c] == IDW'(t))) begin
            push[t]      = !full[t];
            push_data[t] = {IDW'(c), req_data[c*DATA_W +: DATA_W]};
          end
        end
      end
    end
  end

  // request side per core
  always_comb begin
    for (int c = 0; c < N; c++) begin
      pop[c]   = 1'b0;
      flush[c] = 1'b0;
      nv[c]    = 1'b0;
      nok[c]   = 1'b0;
      ntrap[c] = 1'b0;
      ndata[c] = '0;
      nsrc[c]  = '0;
      wait_n[c] = waiting[c];
      if (waiting[c]) begin
        if (cnt[c] != '0) begin
          pop[c] = 1'b1; nv[c] = 1'b1; nok[c] = 1'b1;
          {nsrc[c], ndata[c]} = head[c];
          wait_n[c] = 1'b0;
        end else if (ovf[c]) begin
          nv[c] = 1'b1; ntrap[c] = 1'b1; wait_n[c] = 1'b0;
        end
      end else if (req_valid[c]) begin
        unique case (mq_op_e'(req_op[c*2 +: 2]))
          OP_SEND: begin
            nv[c]    = 1'b1;
            nok[c]   = grant[c] && !full[tgt[c]];
            ntrap[c] = grant[c] && full[tgt[c]];
          end
          OP_RECV: begin
            if (cnt[c] != '0) begin
              pop[c] = 1'b1; nv[c] = 1'b1; nok[c] = 1'b1;
              {nsrc[c], ndata[c]} = head[c];
            end else if (ovf[c] || !req_mode[c]) begin
              nv[c] = 1'b1; ntrap[c] = 1'b1;
            end else begin
              wait_n[c] = 1'b1;
            end
          end
          OP_FLUSH: begin
            flush[c] = 1'b1; nv[c] = 1'b1; nok[c] = 1'b1;
          end
          OP_SELECT: begin
            nv[c]  = 1'b1;
            nok[c] = req_mode[c] ? (cnt[c] != '0) : !full[tgt[c]];
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_q
    mq_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
      .clk(clk), .rst(rst), .push(push[c]), .push_data(push_data[c]),
      .pop(pop[c]), .flush(flush[c]), .head(head[c]), .count(cnt[c])
    );

    // R6: a parked receive stays silent while nothing arrives
    a_r6_wait_quiet: assert property (@(posedge clk) disable iff (rst)
      (waiting[c] && cnt[c] == '0 && !ovf[c]) |=> !rsp_valid[c]);
    // R7: a parked receive traps once the overflow flag is seen
    a_r7_wait_trap: assert property (@(posedge clk) disable iff (rst)
      (waiting[c] && cnt[c] == '0 && ovf[c]) |=> (rsp_valid[c] && rsp_trap[c]));
    // R12: every response has a request or a parked receive behind it
    a_r12_rsp_cause: assert property (@(posedge clk) disable iff (rst)
      rsp_valid[c] |-> $past(req_valid[c] || waiting[c]));
    // R12: ok and trap are never raised together
    a_r12_excl: assert property (@(posedge clk) disable iff (rst)
      !(rsp_ok[c] && rsp_trap[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting   <= '0;
      ovf       <= '0;
      rsp_valid <= '0;
      rsp_ok    <= '0;
      rsp_trap  <= '0;
      rsp_data  <= '0;
      rsp_src   <= '0;
    end else begin
      waiting   <= wait_n;
      rsp_valid <= nv;
      rsp_ok    <= nok;
      rsp_trap  <= ntrap;
      for (int c = 0; c < N; c++) begin
        rsp_data[c*DATA_W +: DATA_W] <= ndata[c];
        rsp_src[c*IDW +: IDW]        <= nsrc[c];
        if (sup_core == IDW'(c)) begin
          if (sup_e == SUP_SET_OVF) ovf[c] <= 1'b1;
          if (sup_e == SUP_CLR_OVF) ovf[c] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: tb/test_mq_unit.sv
`timescale 1ns/1ps
module test_mq_unit;
  localparam int N   = 4;
  localparam int D   = 4;
  localparam int DW  = 32;
  localparam int IDW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]      req_valid, req_mode;
  logic [2*N-1:0]    req_op;
  logic [IDW*N-1:0]  req_target;
  logic [DW*N-1:0]   req_data;
  logic [1:0]        sup_op;
  logic [IDW-1:0]    sup_core, sup_src;
  logic [DW-1:0]     sup_data;
  logic [N-1:0]      rsp_valid, rsp_ok, rsp_trap;
  logic [DW*N-1:0]   rsp_data;
  logic [IDW*N-1:0]  rsp_src;

  mq_unit #(.N_CORES(N), .DEPTH(D), .DATA_W(DW)) i_mq_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_mode(req_mode), .req_target(req_target), .req_data(req_data),
    .sup_op(sup_op), .sup_core(sup_core), .sup_src(sup_src),
    .sup_data(sup_data), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_trap(rsp_trap), .rsp_data(rsp_data), .rsp_src(rsp_src)
  );

  int tests = 0;
  int fails = 0;
  string scen = "reset";

  // stimulus slots
  bit v[N]; int op[N]; bit md[N]; int tg[N]; logic [DW-1:0] dt[N];
  int sop = 3; int score = 0; int ssrc = 0; logic [DW-1:0] sdat = '0;

  // reference model
  logic [DW-1:0] qd[N][D]; int qs[N][D]; int qc[N];
  bit movf[N]; bit mwait[N];

  function automatic void idle();
    for (int c = 0; c < N; c++) begin
      v[c] = 0; op[c] = 0; md[c] = 0; tg[c] = 0; dt[c] = '0;
    end
    sop = 3; score = 0; ssrc = 0; sdat = '0;
  endfunction

  function automatic void req(int c, int o, bit m, int t, logic [DW-1:0] d);
    v[c] = 1; op[c] = o; md[c] = m; tg[c] = t; dt[c] = d;
  endfunction

  task automatic step();
    bit ev[N]; bit eok[N]; bit etr[N]; bit echk[N];
    logic [DW-1:0] ed[N]; int es[N]; string tag[N];
    int c0[N]; int win[N]; bit pv[N]; logic [DW-1:0] pd[N]; int ps[N];
    bit pp[N]; bit fl[N]; bit act;
    for (int c = 0; c < N; c++) begin
      req_valid[c] = v[c]; req_mode[c] = md[c];
      req_op[c*2 +: 2] = 2'(op[c]);
      req_target[c*IDW +: IDW] = IDW'(tg[c]);
      req_data[c*DW +: DW] = dt[c];
    end
    sup_op = 2'(sop); sup_core = IDW'(score); sup_src = IDW'(ssrc); sup_data = sdat;
    for (int c = 0; c < N; c++) begin
      c0[c] = qc[c]; win[c] = -1; pv[c] = 0; pp[c] = 0; fl[c] = 0;
      ev[c] = 0; eok[c] = 0; etr[c] = 0; echk[c] = 0; ed[c] = '0; es[c] = 0;
      tag[c] = "R12";
    end
    for (int c = 0; c < N; c++)
      if (v[c] && !mwait[c] && op[c] == 0 && !(sop == 0 && score == tg[c]) && win[tg[c]] < 0)
        win[tg[c]] = c;
    for (int t = 0; t < N; t++) begin
      if (sop == 0 && score == t) begin
        if (c0[t] < D) begin pv[t] = 1; pd[t] = sdat; ps[t] = ssrc; end
      end else if (win[t] >= 0 && c0[t] < D) begin
        pv[t] = 1; pd[t] = dt[win[t]]; ps[t] = win[t];
      end
    end
    for (int c = 0; c < N; c++) begin
      act = v[c] && !mwait[c];
      if (mwait[c]) begin
        if (c0[c] > 0) begin
          ev[c] = 1; eok[c] = 1; echk[c] = 1; ed[c] = qd[c][0]; es[c] = qs[c][0];
          pp[c] = 1; mwait[c] = 0; tag[c] = "R6";
        end else if (movf[c]) begin
          ev[c] = 1; etr[c] = 1; mwait[c] = 0; tag[c] = "R7";
        end else tag[c] = "R6";
      end else if (act) begin
        case (op[c])
          0: begin
            ev[c] = 1;
            if (win[tg[c]] == c) begin
              eok[c] = c0[tg[c]] < D; etr[c] = !eok[c];
              tag[c] = eok[c] ? "R1" : "R2";
            end else tag[c] = "R3";
          end
          1: begin
            if (c0[c] > 0) begin
              ev[c] = 1; eok[c] = 1; echk[c] = 1; ed[c] = qd[c][0]; es[c] = qs[c][0];
              pp[c] = 1; tag[c] = "R5";
            end else if (movf[c]) begin
              ev[c] = 1; etr[c] = 1; tag[c] = "R7";
            end else if (!md[c]) begin
              ev[c] = 1; etr[c] = 1; tag[c] = pv[c] ? "R10" : "R4";
            end else begin
              mwait[c] = 1; tag[c] = "R6";
            end
          end
          2: begin ev[c] = 1; eok[c] = 1; fl[c] = 1; tag[c] = "R8"; end
          default: begin
            ev[c] = 1; tag[c] = "R9";
            eok[c] = md[c] ? (c0[c] > 0) : (c0[tg[c]] < D);
          end
        endcase
      end
    end
    @(posedge clk);
    for (int t = 0; t < N; t++) begin
      if (fl[t]) qc[t] = 0;
      else if (pp[t]) begin
        for (int k = 0; k < D - 1; k++) begin qd[t][k] = qd[t][k+1]; qs[t][k] = qs[t][k+1]; end
        qc[t]--;
      end
      if (pv[t]) begin qd[t][qc[t]] = pd[t]; qs[t][qc[t]] = ps[t]; qc[t]++; end
    end
    if (sop == 1) movf[score] = 1;
    if (sop == 2) movf[score] = 0;
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      tests++;
      if (rsp_valid[c] !== ev[c] ||
          (ev[c] && (rsp_ok[c] !== eok[c] || rsp_trap[c] !== etr[c])) ||
          (echk[c] && (rsp_data[c*DW +: DW] !== ed[c] || rsp_src[c*IDW +: IDW] !== IDW'(es[c])))) begin
        fails++;
        $display("FAIL [%s] %s core %0d: got v=%0b ok=%0b trap=%0b data=%h src=%0d, exp v=%0b ok=%0b trap=%0b data=%h src=%0d",
          scen, tag[c], c, rsp_valid[c], rsp_ok[c], rsp_trap[c], rsp_data[c*DW +: DW],
          rsp_src[c*IDW +: IDW], ev[c], eok[c], etr[c], ed[c], es[c]);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7421));
    idle();
    for (int c = 0; c < N; c++) begin qc[c] = 0; movf[c] = 0; mwait[c] = 0; end
    req_valid = '0; req_op = '0; req_mode = '0; req_target = '0; req_data = '0;
    sup_op = 2'd3; sup_core = '0; sup_src = '0; sup_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // reset state: R12 no stray response, R9 select sees empty queues
    scen = "R12 R9 reset";
    for (int c = 0; c < N; c++) req(c, 3, 1, 0, '0);
    step();

    scen = "R1 R2 fill";
    for (int k = 0; k < 5; k++) begin idle(); req(1, 0, 0, 0, 32'hA000 + k); step(); end
    scen = "R9 select full";
    idle(); req(2, 3, 0, 0, '0); req(0, 3, 1, 0, '0); step();
    scen = "R5 R4 drain";
    for (int k = 0; k < 5; k++) begin idle(); req(0, 1, 0, 0, '0); step(); end
    scen = "R3 contention";
    idle(); req(1, 0, 0, 0, 32'h11); req(2, 0, 0, 0, 32'h22); req(3, 0, 0, 0, 32'h33); step();
    scen = "R11 R3 refill beats send";
    idle(); req(2, 0, 0, 0, 32'h44); sop = 0; score = 0; ssrc = 3; sdat = 32'h55; step();
    scen = "R8 flush";
    idle(); req(0, 2, 0, 0, '0); req(1, 0, 0, 0, 32'h66); step();
    idle(); req(0, 1, 0, 0, '0); step();
    scen = "R10 same cycle";
    idle(); req(0, 1, 0, 0, '0); req(1, 0, 0, 0, 32'h77); step();
    idle(); req(0, 1, 0, 0, '0); step();
    scen = "R6 blocking";
    idle(); req(0, 1, 1, 0, '0); step();
    idle(); req(0, 0, 0, 1, 32'h99); step();
    idle(); step();
    idle(); req(2, 0, 0, 0, 32'h88); step();
    idle(); step();
    idle(); req(1, 1, 0, 0, '0); step();
    scen = "R7 overflow";
    idle(); req(3, 1, 1, 0, '0); step();
    idle(); sop = 1; score = 3; step();
    idle(); step();
    idle(); req(3, 1, 0, 0, '0); step();
    idle(); req(3, 1, 1, 0, '0); step();
    scen = "R11 clear overflow";
    idle(); sop = 2; score = 3; step();
    idle(); req(0, 0, 0, 3, 32'hBB); step();
    idle(); req(3, 1, 1, 0, '0); step();

    scen = "random R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12";
    for (int i = 0; i < 3000; i++) begin
      idle();
      for (int c = 0; c < N; c++) begin
        if ($urandom_range(0, 99) < 60) begin
          int r = $urandom_range(0, 9);
          req(c, (r < 4) ? 0 : (r < 7) ? 1 : (r < 8) ? 2 : 3,
              1'($urandom_range(0, 1)), $urandom_range(0, N - 1), $urandom);
        end
      end
      if ($urandom_range(0, 99) < 15) begin
        sop = $urandom_range(0, 2); score = $urandom_range(0, N - 1);
        ssrc = $urandom_range(0, N - 1); sdat = $urandom;
      end
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule